// File: doc/BRIEF.md
# Paged flash address translation unit

This block turns a virtual access from one of two CPUs into a 24-bit physical address on external flash. It keeps a table of mapping words, each naming one 64 KB flash page. The word used for an access is chosen from the CPU, the process ID, the virtual region number and the page index inside that region. A lookup returns, one cycle later, the physical address (the page number from the mapping word followed by the 16 offset bits of the virtual address) and a fault flag.

Each CPU has its own special-mode enable. With special mode off, and for processes 0 and 1 in either mode, every process shares one set of words. With special mode on, processes 2 to 7 each get private words for regions 2, 3 and 4 of the map, and cannot reach flash through regions 0 and 1. The table index space is 4096 words wide: words 0 to 2047 belong to the first CPU and words 2048 to 4095 to the second, with the same layout in each half. Only the first 1168 words of each half are implemented.

Top module: `flashmap_xlate`

## Requirements
- R1: A mapping word written on `wr_word` holds the flash page number in bits 7:0 and a not-mapped flag in bit 8 (1 = the word maps nothing); bits 31:9 are ignored.
- R2: `rsp_valid` is high exactly one cycle after `lk_req` was high; when `rsp_fault` is low, `rsp_paddr` equals {page number, `lk_addr[15:0]`} of that request.
- R3: `wr_index[11]` selects the CPU half (second CPU = first CPU index + 2048) and `wr_index[10:0]` the word inside the half; writes whose in-half index is 1168 or more are dropped and alter no other word.
- R4: In regions 0 to 3 (`lk_addr[21:16]` is the page index, 0 to 63), a process using the shared layout (special mode off, or PID 0 or 1) uses word region*64 + page; for example word 0x30 holding 0x007 maps region 0 offset 0x30_2375 to 0x07_2375.
- R5: In region 4 a process using the shared layout uses word 1056 + page, for pages 0 to 15.
- R6: In special mode a process with PID 2 to 7 uses word 256 + 128*(PID-2) + (region-2)*64 + page in regions 2 and 3, and faults in regions 0 and 1.
- R7: In special mode a process with PID 2 to 7 uses word 1072 + 16*(PID-2) + page in region 4.
- R8: `mode_special[0]` governs only lookups with `lk_cpu`=0 and `mode_special[1]` only lookups with `lk_cpu`=1.
- R9: A lookup faults (`rsp_fault`=1, `rsp_paddr`=0) when its word has bit 8 set, when its region is above 4, or when a region 4 page index is 16 or more.
- R10: After reset `rsp_valid` is low and every word is not-mapped.
- R11: A write is seen by lookups issued in the following cycle; a lookup issued in the same cycle as a write to its word returns the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_special | input | 2 | Special-mode enable, one bit per CPU |
| wr_en | input | 1 | Write a mapping word |
| wr_index | input | 12 | Word index: bit 11 CPU, bits 10:0 word |
| wr_word | input | 32 | Mapping word (bits 8:0 used) |
| lk_req | input | 1 | Lookup request |
| lk_cpu | input | 1 | Requesting CPU |
| lk_pid | input | 3 | Process ID |
| lk_region | input | 3 | Virtual region number |
| lk_addr | input | 22 | Address inside the region: page in 21:16, offset in 15:0 |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_fault | output | 1 | Lookup faulted |
| rsp_paddr | output | 24 | Physical flash address |

## Verification
The hardest cases to reach from the ports are mapped hits on private special-mode words, above all the last word of the second CPU's half (PID 7, region 4, page 15), because random lookups almost always land on words never written. The random phase therefore writes the word a lookup will use in the cycle just before it about half the time, while per-CPU modes flip every few dozen operations. Directed cases cover the dropped out-of-range write that would alias into the other CPU's storage and the same-cycle write-and-lookup.

// File: rtl/flashmap_pkg.sv
// Package: shared constants and types for the flash translation unit.
// Assumes a 64 KB page, an 8-bit page number and a two-CPU index space.
package flashmap_pkg;
    localparam int PAGE_W        = 8;
    localparam int OFS_W         = 16;
    localparam int PADDR_W       = PAGE_W + OFS_W;
    localparam int NUM_CPU       = 2;
    localparam int CPU_SEL_W     = $clog2(NUM_CPU);
    localparam int HALF_W        = 11;
    localparam int IDX_W         = HALF_W + CPU_SEL_W;
    localparam int PID_W         = 3;
    localparam int REGION_W      = 3;
    localparam int PG_IDX_W      = 6;
    localparam int INREG_W       = PG_IDX_W + OFS_W;
    localparam int LOW_PAGES     = 64;
    localparam int HI_PAGES      = 16;
    localparam int HI_REGION     = 4;
    localparam int PRIV_LOW_BASE = 256;
    localparam int PRIV_LOW_STEP = 2 * LOW_PAGES;
    localparam int SHARED_HI     = 1056;
    localparam int PRIV_HI_BASE  = SHARED_HI + HI_PAGES;
    localparam int FIRST_PRIV    = 2;
    localparam int NUM_PRIV      = 6;
    localparam int LOCAL_DEPTH   = PRIV_HI_BASE + NUM_PRIV * HI_PAGES;
    localparam int STORE_DEPTH   = NUM_CPU * LOCAL_DEPTH;
    localparam int STORE_W       = $clog2(STORE_DEPTH);

    typedef struct packed {
        logic              unmapped;
        logic [PAGE_W-1:0] page;
    } map_entry_t;
endpackage

// File: rtl/flashmap_index.sv
// Module: computes the in-half word index for one lookup from mode, PID,
// region and page index. Purely combinational. geo_ok is low when the
// region/page combination has no word (the lookup must fault).
module flashmap_index
    import flashmap_pkg::*;
(
    input  logic                special,
    input  logic [PID_W-1:0]    pid,
    input  logic [REGION_W-1:0] region,
    input  logic [PG_IDX_W-1:0] page_idx,
    output logic [HALF_W-1:0]   local_idx,
    output logic                geo_ok
);
    logic             is_private;
    logic [HALF_W-1:0] base;
    logic [HALF_W-1:0] pid_ofs;

    // Pick the layout and the first word of the addressed region.
    always_comb begin
        is_private = special && (pid >= PID_W'(FIRST_PRIV));
        pid_ofs    = HALF_W'(pid) - HALF_W'(FIRST_PRIV);
        base       = '0;
        geo_ok     = 1'b0;
        if (region < REGION_W'(HI_REGION)) begin
            if (is_private) begin
                geo_ok = (region >= REGION_W'(2));
                base   = HALF_W'(PRIV_LOW_BASE) + pid_ofs * HALF_W'(PRIV_LOW_STEP)
                       + (HALF_W'(region) - HALF_W'(2)) * HALF_W'(LOW_PAGES);
            end else begin
                geo_ok = 1'b1;
                base   = HALF_W'(region) * HALF_W'(LOW_PAGES);
            end
        end else if (region == REGION_W'(HI_REGION)) begin
            geo_ok = (page_idx < PG_IDX_W'(HI_PAGES));
            base   = is_private ? HALF_W'(PRIV_HI_BASE) + pid_ofs * HALF_W'(HI_PAGES)
                                : HALF_W'(SHARED_HI);
        end
        local_idx = geo_ok ? base + HALF_W'(page_idx) : '0;
    end
endmodule

// File: rtl/flashmap_wr_decode.sv
// Module: maps a write index of the full two-half space onto the compact
// storage. Assumes each half stores only its first LOCAL_DEPTH words;
// other indices are reported as not storable.
module flashmap_wr_decode
    import flashmap_pkg::*;
(
    input  logic [IDX_W-1:0]   wr_index,
    output logic [STORE_W-1:0] store_addr,
    output logic               store_ok
);
    logic [HALF_W-1:0]    in_half;
    logic [CPU_SEL_W-1:0] cpu;

    // Split the index and fold the CPU half onto packed storage.
    always_comb begin
        cpu        = wr_index[IDX_W-1 -: CPU_SEL_W];
        in_half    = wr_index[HALF_W-1:0];
        store_ok   = (in_half < HALF_W'(LOCAL_DEPTH));
        store_addr = store_ok ? STORE_W'(cpu) * STORE_W'(LOCAL_DEPTH) + STORE_W'(in_half) : '0;
    end
endmodule

// File: rtl/flashmap_table.sv
// Module: mapping word storage with one write port and one asynchronous
// read port. The not-mapped flags are reset to 1; page numbers are not
// reset, since a word is only used once its flag has been cleared.
module flashmap_table
    import flashmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [STORE_W-1:0] wr_addr,
    input  map_entry_t         wr_entry,
    input  logic [STORE_W-1:0] rd_addr,
    output map_entry_t         rd_entry
);
    logic [PAGE_W-1:0]      pages [STORE_DEPTH];
    logic [STORE_DEPTH-1:0] unmapped_flags;

    // Flag store: all not-mapped after reset, updated on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unmapped_flags <= '1;
        end else if (wr_en) begin
            unmapped_flags[wr_addr] <= wr_entry.unmapped;
        end
    end

    // Page number store, no reset needed.
    always_ff @(posedge clk) begin
        if (rst_n && wr_en) begin
            pages[wr_addr] <= wr_entry.page;
        end
    end

    // Read the addressed word; out-of-range addresses read as not-mapped.
    always_comb begin
        if (rd_addr < STORE_W'(STORE_DEPTH)) begin
            rd_entry.unmapped = unmapped_flags[rd_addr];
            rd_entry.page     = pages[rd_addr];
        end else begin
            rd_entry.unmapped = 1'b1;
            rd_entry.page     = '0;
        end
    end

    assert_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (unmapped_flags[$past(wr_addr)] == $past(wr_entry.unmapped))
               && (pages[$past(wr_addr)] == $past(wr_entry.page)));
endmodule

// File: rtl/flashmap_xlate.sv
// Module: top of the flash translation unit. Decodes writes into the
// table, computes the word for each lookup, and registers the physical
// address and fault flag. Assumes one lookup per cycle and no back-pressure.
module flashmap_xlate
    import flashmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CPU-1:0]   mode_special,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_index,
    input  logic [31:0]          wr_word,
    input  logic                 lk_req,
    input  logic [CPU_SEL_W-1:0] lk_cpu,
    input  logic [PID_W-1:0]     lk_pid,
    input  logic [REGION_W-1:0]  lk_region,
    input  logic [INREG_W-1:0]   lk_addr,
    output logic                 rsp_valid,
    output logic                 rsp_fault,
    output logic [PADDR_W-1:0]   rsp_paddr
);
    logic [STORE_W-1:0] wr_addr;
    logic               wr_ok;
    map_entry_t         wr_entry;
    logic [HALF_W-1:0]  lk_local;
    logic               lk_geo_ok;
    logic [STORE_W-1:0] rd_addr;
    map_entry_t         rd_entry;
    logic               hit_fault;

    flashmap_wr_decode u_wr_decode (
        .wr_index   (wr_index),
        .store_addr (wr_addr),
        .store_ok   (wr_ok)
    );

    // Keep only the used bits of the incoming mapping word.
    always_comb begin
        wr_entry.unmapped = wr_word[PAGE_W];
        wr_entry.page     = wr_word[PAGE_W-1:0];
    end

    flashmap_index u_index (
        .special   (mode_special[lk_cpu]),
        .pid       (lk_pid),
        .region    (lk_region),
        .page_idx  (lk_addr[INREG_W-1:OFS_W]),
        .local_idx (lk_local),
        .geo_ok    (lk_geo_ok)
    );

    // Place the lookup's in-half word inside the requesting CPU's storage.
    always_comb begin
        rd_addr   = STORE_W'(lk_cpu) * STORE_W'(LOCAL_DEPTH) + STORE_W'(lk_local);
        hit_fault = !lk_geo_ok || rd_entry.unmapped;
    end

    flashmap_table u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en && wr_ok),
        .wr_addr  (wr_addr),
        .wr_entry (wr_entry),
        .rd_addr  (rd_addr),
        .rd_entry (rd_entry)
    );

    // Register the lookup result; faults clear the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= lk_req;
            if (lk_req) begin
                rsp_fault <= hit_fault;
                rsp_paddr <= hit_fault ? '0 : {rd_entry.page, lk_addr[OFS_W-1:0]};
            end
        end
    end

    assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_paddr == '0);
    assert_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid && (rsp_fault || rsp_paddr[OFS_W-1:0] == $past(lk_addr[OFS_W-1:0])));
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);
    assert_bad_region_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && (lk_region > REGION_W'(HI_REGION)) |=> rsp_fault);
    assert_private_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && mode_special[lk_cpu] && (lk_pid >= PID_W'(FIRST_PRIV))
        && (lk_region < REGION_W'(2)) |=> rsp_fault);
endmodule

// File: tb/test_flashmap_xlate.sv
module test_flashmap_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_special = '0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_index = '0;
    logic [31:0] wr_word = '0;
    logic        lk_req = 1'b0;
    logic        lk_cpu = 1'b0;
    logic [2:0]  lk_pid = '0;
    logic [2:0]  lk_region = '0;
    logic [21:0] lk_addr = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [23:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    logic [8:0] ref_mem [4096];

    flashmap_xlate i_flashmap_xlate (
        .clk(clk), .rst_n(rst_n), .mode_special(mode_special),
        .wr_en(wr_en), .wr_index(wr_index), .wr_word(wr_word),
        .lk_req(lk_req), .lk_cpu(lk_cpu), .lk_pid(lk_pid),
        .lk_region(lk_region), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    always #4 clk = ~clk;

    // Reference word index from the requirements; -1 means no word.
    function automatic int ref_index(bit cpu, bit spec, int pid, int region, int page);
        int loc;
        bit priv = spec && (pid >= 2);
        if (region > 4) return -1;
        if (region == 4) begin
            if (page >= 16) return -1;
            loc = priv ? (1072 + 16 * (pid - 2) + page) : (1056 + page);
        end else if (priv) begin
            if (region < 2) return -1;
            loc = 256 + 128 * (pid - 2) + 64 * (region - 2) + page;
        end else begin
            loc = 64 * region + page;
        end
        return (cpu ? 2048 : 0) + loc;
    endfunction

    task automatic check(string tag, bit c, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!c) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, check at the next one, go idle.
    task automatic op(string tag, bit do_wr, int widx, logic [31:0] word,
                      bit do_lk, bit cpu, int pid, int region, logic [21:0] addr);
        int idx;
        logic        exp_fault;
        logic [23:0] exp_paddr;
        wr_en = do_wr; wr_index = 12'(widx); wr_word = word;
        lk_req = do_lk; lk_cpu = cpu; lk_pid = 3'(pid); lk_region = 3'(region); lk_addr = addr;
        idx = ref_index(cpu, mode_special[cpu], pid, region, int'(addr[21:16]));
        exp_fault = (idx < 0) ? 1'b1 : ref_mem[idx][8];
        exp_paddr = exp_fault ? 24'h0 : {ref_mem[idx][7:0], addr[15:0]};
        if (do_wr && ((widx % 2048) < 1168)) ref_mem[widx] = word[8:0];
        @(negedge clk);
        if (do_lk)
            check(tag, rsp_valid === 1'b1 && rsp_fault === exp_fault && rsp_paddr === exp_paddr,
                  {7'h0, rsp_fault, rsp_paddr}, {7'h0, exp_fault, exp_paddr});
        else
            check(tag, rsp_valid === 1'b0, 32'(rsp_valid), 32'h0);
        wr_en = 1'b0; lk_req = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors + 0);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        foreach (ref_mem[i]) ref_mem[i] = 9'h100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: idle after reset, every word not-mapped.
        check("R10 valid low", rsp_valid === 1'b0, 32'(rsp_valid), 32'h0);
        op("R10 unmapped", 0, 0, 0, 1, 0, 0, 0, 22'h00_1234);
        // R4: worked example in normal mode.
        op("R4 write", 1, 'h30, 32'h007, 0, 0, 0, 0, 0);
        op("R4 lookup", 0, 0, 0, 1, 0, 0, 0, 22'h30_2375);
        // R1: upper bits ignored; bit 8 marks not-mapped.
        op("R1 write", 1, 5, 32'hFFFF_FE07, 0, 0, 0, 0, 0);
        op("R1 upper ignored", 0, 0, 0, 1, 0, 1, 0, 22'h05_00FF);
        op("R1 write2", 1, 5, 32'h0000_01AA, 0, 0, 0, 0, 0);
        op("R1 unmapped bit", 0, 0, 0, 1, 0, 0, 0, 22'h05_00FF);
        // R11: same-cycle lookup sees old word, next cycle the new one.
        op("R11 same cycle", 1, 'h30, 32'h011, 1, 0, 0, 0, 22'h30_0001);
        op("R11 next cycle", 0, 0, 0, 1, 0, 0, 0, 22'h30_0001);
        // R3: second CPU half, and a dropped out-of-range write.
        op("R3 write cpu1", 1, 'h830, 32'h022, 0, 0, 0, 0, 0);
        op("R3 cpu1 lookup", 0, 0, 0, 1, 1, 0, 0, 22'h30_4444);
        op("R3 cpu0 intact", 0, 0, 0, 1, 0, 0, 0, 22'h30_4444);
        op("R3 dropped write", 1, 1200, 32'h033, 0, 0, 0, 0, 0);
        op("R3 no alias", 0, 0, 0, 1, 1, 0, 0, 22'h20_0000);
        // R5: shared region 4.
        op("R5 write", 1, 1059, 32'h0C5, 0, 0, 0, 0, 0);
        op("R5 lookup", 0, 0, 0, 1, 0, 4, 4, 22'h03_ABCD);
        // R6/R7: special mode on CPU 0 only.
        mode_special = 2'b01;
        op("R6 write", 1, 453, 32'h0E1, 0, 0, 0, 0, 0);
        op("R6 lookup", 0, 0, 0, 1, 0, 3, 3, 22'h05_1111);
        op("R6 low region faults", 0, 0, 0, 1, 0, 3, 0, 22'h05_1111);
        op("R7 write last", 1, 1167, 32'h0F0, 0, 0, 0, 0, 0);
        op("R7 lookup last", 0, 0, 0, 1, 0, 7, 4, 22'h0F_2222);
        op("R9 page beyond", 0, 0, 0, 1, 0, 7, 4, 22'h10_2222);
        // R8: CPU 1 still in normal mode.
        op("R8 write", 1, 2245, 32'h099, 0, 0, 0, 0, 0);
        op("R8 cpu1 normal", 0, 0, 0, 1, 1, 3, 3, 22'h05_3333);
        op("R9 region 5", 0, 0, 0, 1, 0, 0, 5, 22'h00_0000);
        op("R9 region4 page20", 0, 0, 0, 1, 1, 0, 4, 22'h14_0000);
        // Random mix: R2, R9 and the layouts under changing modes.
        for (int n = 0; n < 3000; n++) begin
            bit cpu = 1'($urandom);
            int pid = int'($urandom % 8);
            int region = int'($urandom % 6);
            logic [21:0] addr = 22'($urandom);
            int idx;
            if (n % 40 == 0) mode_special = 2'($urandom);
            if ($urandom % 4 != 0 && region == 4) addr[21:20] = 2'b00;
            idx = ref_index(cpu, mode_special[cpu], pid, region, int'(addr[21:16]));
            if (idx >= 0 && $urandom % 2 == 0)
                op("R2 random write", 1, idx, $urandom, 0, 0, 0, 0, 0);
            op("R2 R9 random", $urandom % 8 == 0, int'($urandom % 4096), $urandom,
               1, cpu, pid, region, addr);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule